// File: doc/BRIEF.md
# Four-Channel DMA Host Register File

This block is the register file a host processor uses to program a four-channel DMA controller of the classic personal-computer kind. The host reaches it over an 8-bit I/O bus: a 4-bit port offset, separate write and read strobes, write data and read data. Each channel keeps a 16-bit base address, a 16-bit current address, a 16-bit base count and a 16-bit current count. A single 8-bit port carries each of these 16-bit values as two byte operations in a row. One byte-pointer flip-flop, shared by every channel, decides whether a given access reaches the low byte or the high byte.

The block also holds the per-channel mask bits, per-channel mode fields and the command byte, and drives them to the transfer engine. The engine reports progress back through a one-cycle step pulse per channel. On each step the current address moves by one and the current count drops by one. Terminal count is latched into the status byte, and an auto-initialising channel reloads its current copies from the base copies. Bus arbitration, memory-cycle timing and page extension registers belong to other blocks.

Top module: `dma_chan_regs`

## Requirements
- R1: After a synchronous active-low reset, all four mask bits are 1, the command byte and every mode field are 0, every address and count is 0, the byte pointer selects the low byte, and no terminal-count flag is set.
- R2: A write to an address or count port loads the written byte into both the base and the current copy. A read returns the current copy. A low-byte then high-byte write followed by two reads returns the same two bytes.
- R3: Every byte read or write to offsets 0 to 7 toggles the byte pointer (0 selects the low byte, 1 selects the high byte). The pointer is shared by all channels and by address and count. A write of any value to offset 0xC sets it back to the low byte.
- R4: Channel n's address register is at offset 2n and its count register is at offset 2n+1.
- R5: A write to offset 0xA selects a channel with data bits 1:0. It sets that channel's mask if data bit 2 is 1 and clears it if bit 2 is 0. The other mask bits are unchanged.
- R6: A write to offset 0xE clears all mask bits. A write to offset 0xF loads mask bit n from data bit n, for n from 0 to 3.
- R7: A write to offset 0xB selects a channel with data bits 1:0 and stores data bits 7:2 as that channel's 6-bit mode, driven on `chan_mode[6n+5:6n]`. In that field, bit 2 (data bit 4) is auto-initialise and bit 3 (data bit 5) is decrement.
- R8: A write to offset 0x8 loads the command byte. A read of offset 0x8 returns the status byte, with the request inputs in bits 7:4 and the terminal-count flags in bits 3:0. The read clears the flags. A flag set in the same cycle as the read survives it.
- R9: A write to offset 0xD is a master clear. It resets the byte pointer, sets all masks, and clears the command byte, the mode fields and the terminal-count flags. Addresses and counts are kept. A read of 0xD returns 0.
- R10: A step pulse moves the channel's current address by +1, or by -1 when the decrement bit is set. It lowers the current count by 1 and leaves both base copies unchanged.
- R11: A step taken at current count 0 wraps the count to 0xFFFF and sets that channel's terminal-count flag. Reading the count port afterwards returns 0xFF for both bytes.
- R12: When the auto-initialise bit is set, a terminal-count step reloads the current address and current count from their base copies.
- R13: In a cycle where the host writes a channel's address or count and that channel also steps, the host write takes effect on that register and the step is dropped for it. The step still applies to the register that was not written.
- R14: `io_rdata` is 0 while `io_rd` is low, and a read of any write-only offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 4 | Port offset |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_rd | input | 1 | Read strobe, one cycle per byte |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid in the cycle of `io_rd` |
| xfer_step | input | 4 | Per-channel one-cycle transfer step from the engine |
| dreq | input | 4 | Per-channel request lines reported in status |
| chan_mask | output | 4 | Per-channel mask, 1 = disabled |
| chan_mode | output | 24 | Four 6-bit mode fields, channel n at bits 6n+5:6n |
| cmd_reg | output | 8 | Command byte |
| cur_addr_bus | output | 64 | Current addresses, channel n at bits 16n+15:16n |
| cur_cnt_bus | output | 64 | Current counts, channel n at bits 16n+15:16n |

## Verification
The assertions assume that the host never raises `io_wr` and `io_rd` in the same cycle, and that each strobe lasts one cycle with the offset and data steady during it. The byte-pointer and per-register checks rely on this. The bench drives every bus access through one task that raises exactly one strobe for one cycle and drops it afterwards. It only issues a step together with a host write when it is deliberately testing the precedence rule.

// File: rtl/dma_regs_pkg.sv
// Package dma_regs_pkg: port offsets, mode-field bit positions and the
// decoded-access structure shared by the register-file modules.
package dma_regs_pkg;
    localparam int DATA_W = 8;
    localparam int REG_W  = 2 * DATA_W;
    localparam int MODE_W = 6;
    localparam int OFS_W  = 4;

    localparam logic [OFS_W-1:0] OFS_CMD     = 4'h8;
    localparam logic [OFS_W-1:0] OFS_MASK1   = 4'hA;
    localparam logic [OFS_W-1:0] OFS_MODE    = 4'hB;
    localparam logic [OFS_W-1:0] OFS_CLRPTR  = 4'hC;
    localparam logic [OFS_W-1:0] OFS_MCLR    = 4'hD;
    localparam logic [OFS_W-1:0] OFS_CLRMASK = 4'hE;
    localparam logic [OFS_W-1:0] OFS_ALLMASK = 4'hF;

    // bit positions inside the stored 6-bit mode field (data bits 7:2)
    localparam int MODE_AUTO_BIT = 2;
    localparam int MODE_DEC_BIT  = 3;

    typedef struct packed {
        logic       byte_acc;
        logic       chan_wr;
        logic       is_cnt;
        logic [1:0] chan;
        logic       cmd_wr;
        logic       stat_rd;
        logic       mask1_wr;
        logic       mode_wr;
        logic       clr_ptr;
        logic       mclr;
        logic       clr_masks;
        logic       all_mask_wr;
    } dec_t;
endpackage

// File: rtl/dma_port_decode.sv
// Module dma_port_decode: turns the port offset and strobes into one
// decoded access. Assumes at most one strobe is high per cycle.
module dma_port_decode
    import dma_regs_pkg::*;
(
    input  logic [OFS_W-1:0] io_addr,
    input  logic             io_wr,
    input  logic             io_rd,
    output dec_t             dec
);
    // Purpose: classify the current bus access.
    always_comb begin
        dec        = '0;
        dec.chan   = io_addr[2:1];
        dec.is_cnt = io_addr[0];
        if (!io_addr[3]) begin
            dec.chan_wr  = io_wr;
            dec.byte_acc = io_wr | io_rd;
        end else begin
            case (io_addr)
                OFS_CMD: begin
                    dec.cmd_wr  = io_wr;
                    dec.stat_rd = io_rd;
                end
                OFS_MASK1:   dec.mask1_wr    = io_wr;
                OFS_MODE:    dec.mode_wr     = io_wr;
                OFS_CLRPTR:  dec.clr_ptr     = io_wr;
                OFS_MCLR:    dec.mclr        = io_wr;
                OFS_CLRMASK: dec.clr_masks   = io_wr;
                OFS_ALLMASK: dec.all_mask_wr = io_wr;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dma_chan_slot.sv
// Module dma_chan_slot: base/current address and count for one channel.
// Host byte writes load base and current together and take precedence over
// an engine step on the same register. A step at count 0 flags terminal
// count and, with auto-initialise, reloads the current copies from base.
module dma_chan_slot
    import dma_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_wr,
    input  logic              cnt_wr,
    input  logic              hi_sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              step,
    input  logic              dec_mode,
    input  logic              auto_init,
    output logic [REG_W-1:0]  cur_addr,
    output logic [REG_W-1:0]  cur_cnt,
    output logic              tc_hit
);
    logic [REG_W-1:0] base_addr, base_cnt;
    logic [REG_W-1:0] addr_merge, cnt_merge;
    logic             reload;

    // Purpose: place the written byte into the selected half of the base value.
    always_comb begin
        addr_merge = hi_sel ? {wdata, base_addr[DATA_W-1:0]} : {base_addr[REG_W-1:DATA_W], wdata};
        cnt_merge  = hi_sel ? {wdata, base_cnt[DATA_W-1:0]}  : {base_cnt[REG_W-1:DATA_W], wdata};
        tc_hit     = step && !cnt_wr && (cur_cnt == '0);
        reload     = tc_hit && auto_init;
    end

    // Purpose: address registers, host write over step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
            cur_addr  <= '0;
        end else if (addr_wr) begin
            base_addr <= addr_merge;
            cur_addr  <= addr_merge;
        end else if (reload) begin
            cur_addr  <= base_addr;
        end else if (step) begin
            cur_addr  <= dec_mode ? cur_addr - 1'b1 : cur_addr + 1'b1;
        end
    end

    // Purpose: count registers, host write over step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_cnt <= '0;
            cur_cnt  <= '0;
        end else if (cnt_wr) begin
            base_cnt <= cnt_merge;
            cur_cnt  <= cnt_merge;
        end else if (reload) begin
            cur_cnt  <= base_cnt;
        end else if (step) begin
            cur_cnt  <= cur_cnt - 1'b1;
        end
    end
endmodule

// File: rtl/dma_ctrl_regs.sv
// Module dma_ctrl_regs: shared byte pointer, masks, modes, command byte and
// terminal-count flags. Master clear resets all of them except addresses.
module dma_ctrl_regs
    import dma_regs_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  dec_t                  dec,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [NCH-1:0]        tc_hit,
    output logic                  ptr_hi,
    output logic [NCH-1:0]        chan_mask,
    output logic [NCH*MODE_W-1:0] chan_mode,
    output logic [DATA_W-1:0]     cmd_reg,
    output logic [NCH-1:0]        tc_flags
);
    localparam int CHW = $clog2(NCH);
    logic [CHW-1:0] sel;

    // Purpose: channel selected by a mask or mode write.
    always_comb sel = wdata[CHW-1:0];

    // Purpose: byte pointer, toggled by each channel-register byte access.
    always_ff @(posedge clk) begin
        if (!rst_n || dec.mclr || dec.clr_ptr) ptr_hi <= 1'b0;
        else if (dec.byte_acc)                 ptr_hi <= ~ptr_hi;
    end

    // Purpose: per-channel mask bits.
    always_ff @(posedge clk) begin
        if (!rst_n || dec.mclr)   chan_mask      <= '1;
        else if (dec.clr_masks)   chan_mask      <= '0;
        else if (dec.all_mask_wr) chan_mask      <= wdata[NCH-1:0];
        else if (dec.mask1_wr)    chan_mask[sel] <= wdata[2];
    end

    // Purpose: per-channel mode fields from data bits 7:2.
    always_ff @(posedge clk) begin
        if (!rst_n || dec.mclr) chan_mode <= '0;
        else if (dec.mode_wr)   chan_mode[sel*MODE_W +: MODE_W] <= wdata[DATA_W-1:2];
    end

    // Purpose: command byte.
    always_ff @(posedge clk) begin
        if (!rst_n || dec.mclr) cmd_reg <= '0;
        else if (dec.cmd_wr)    cmd_reg <= wdata;
    end

    // Purpose: terminal-count flags, cleared by a status read, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n || dec.mclr) tc_flags <= '0;
        else tc_flags <= (tc_flags & ~{NCH{dec.stat_rd}}) | tc_hit;
    end
endmodule

// File: rtl/dma_chan_regs.sv
// Module dma_chan_regs: top of the host register file for a four-channel
// DMA controller. Ties decode, control registers and channel slots together
// and forms the read data. Assumes NCH = 4 so that the channel ports fill
// offsets 0..7 and status fits one byte.
module dma_chan_regs
    import dma_regs_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [OFS_W-1:0]      io_addr,
    input  logic                  io_wr,
    input  logic                  io_rd,
    input  logic [DATA_W-1:0]     io_wdata,
    output logic [DATA_W-1:0]     io_rdata,
    input  logic [NCH-1:0]        xfer_step,
    input  logic [NCH-1:0]        dreq,
    output logic [NCH-1:0]        chan_mask,
    output logic [NCH*MODE_W-1:0] chan_mode,
    output logic [DATA_W-1:0]     cmd_reg,
    output logic [NCH*REG_W-1:0]  cur_addr_bus,
    output logic [NCH*REG_W-1:0]  cur_cnt_bus
);
    dec_t             dec;
    logic             ptr_hi;
    logic [NCH-1:0]   tc_flags;
    logic [NCH-1:0]   tc_hit;
    logic [REG_W-1:0] cur_addr_q [NCH];
    logic [REG_W-1:0] cur_cnt_q  [NCH];

    dma_port_decode u_dec (
        .io_addr (io_addr),
        .io_wr   (io_wr),
        .io_rd   (io_rd),
        .dec     (dec)
    );

    dma_ctrl_regs #(.NCH(NCH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .dec       (dec),
        .wdata     (io_wdata),
        .tc_hit    (tc_hit),
        .ptr_hi    (ptr_hi),
        .chan_mask (chan_mask),
        .chan_mode (chan_mode),
        .cmd_reg   (cmd_reg),
        .tc_flags  (tc_flags)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        logic sel_me;
        assign sel_me = dec.chan_wr && (dec.chan == i[1:0]);
        dma_chan_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .addr_wr   (sel_me && !dec.is_cnt),
            .cnt_wr    (sel_me && dec.is_cnt),
            .hi_sel    (ptr_hi),
            .wdata     (io_wdata),
            .step      (xfer_step[i]),
            .dec_mode  (chan_mode[i*MODE_W + MODE_DEC_BIT]),
            .auto_init (chan_mode[i*MODE_W + MODE_AUTO_BIT]),
            .cur_addr  (cur_addr_q[i]),
            .cur_cnt   (cur_cnt_q[i]),
            .tc_hit    (tc_hit[i])
        );
        assign cur_addr_bus[i*REG_W +: REG_W] = cur_addr_q[i];
        assign cur_cnt_bus[i*REG_W +: REG_W]  = cur_cnt_q[i];
    end

    // Purpose: read data mux; channel byte by pointer, status at 0x8.
    always_comb begin
        logic [REG_W-1:0] word;
        word     = dec.is_cnt ? cur_cnt_q[dec.chan] : cur_addr_q[dec.chan];
        io_rdata = '0;
        if (io_rd) begin
            if (!io_addr[3])    io_rdata = ptr_hi ? word[REG_W-1:DATA_W] : word[DATA_W-1:0];
            else if (dec.stat_rd) io_rdata = {dreq, tc_flags};
        end
    end
endmodule

// File: rtl/dma_chan_regs_chk.sv
// Module dma_chan_regs_chk: temporal checks on the register file, bound to
// every instance of dma_chan_regs. Assumes one bus strobe per cycle.
module dma_chan_regs_chk
    import dma_regs_pkg::*;
#(
    parameter int NCH = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [OFS_W-1:0]     io_addr,
    input logic                 io_wr,
    input logic                 io_rd,
    input logic [DATA_W-1:0]    io_wdata,
    input logic [NCH-1:0]       xfer_step,
    input logic [NCH-1:0]       chan_mask,
    input logic [DATA_W-1:0]    cmd_reg,
    input logic [NCH*REG_W-1:0] cur_cnt_bus,
    input logic                 ptr_hi,
    input logic [NCH-1:0]       tc_flags
);
    p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && io_rd));

    p_ptr_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((io_wr || io_rd) && !io_addr[3]) |=> (ptr_hi != $past(ptr_hi)));

    p_mask_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == OFS_MASK1) |=> (chan_mask[$past(io_wdata[1:0])] == $past(io_wdata[2])));

    p_mask_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == OFS_CLRMASK) |=> (chan_mask == '0));

    p_master_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == OFS_MCLR) |=> (chan_mask == '1 && cmd_reg == '0 && !ptr_hi));

    for (genvar i = 0; i < NCH; i++) begin : g_ck
        logic cnt_hit;
        assign cnt_hit = io_wr && (io_addr == OFS_W'(2*i+1));

        p_step_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (xfer_step[i] && !cnt_hit && cur_cnt_bus[i*REG_W +: REG_W] != '0)
            |=> (cur_cnt_bus[i*REG_W +: REG_W] == $past(cur_cnt_bus[i*REG_W +: REG_W]) - 1'b1));

        p_tc_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (xfer_step[i] && !cnt_hit && cur_cnt_bus[i*REG_W +: REG_W] == '0
             && !(io_wr && io_addr == OFS_MCLR)) |=> tc_flags[i]);
    end
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/dma_chan_regs_bench.sv
module dma_chan_regs_bench;
    import dma_regs_pkg::*;

    localparam int NCH = 4;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [OFS_W-1:0]      io_addr = '0;
    logic                  io_wr = 1'b0;
    logic                  io_rd = 1'b0;
    logic [DATA_W-1:0]     io_wdata = '0;
    logic [DATA_W-1:0]     io_rdata;
    logic [NCH-1:0]        xfer_step = '0;
    logic [NCH-1:0]        dreq = '0;
    logic [NCH-1:0]        chan_mask;
    logic [NCH*MODE_W-1:0] chan_mode;
    logic [DATA_W-1:0]     cmd_reg;
    logic [NCH*REG_W-1:0]  cur_addr_bus;
    logic [NCH*REG_W-1:0]  cur_cnt_bus;

    int checks = 0;
    int fails  = 0;
    logic [7:0] rv;

    dma_chan_regs #(.NCH(NCH)) u_dma_chan_regs (.*);

    always #5 clk = ~clk;

    // wr, rd, offset, data, what to check (0 none,1 rdata,2 mask,3 cmd), expected
    typedef struct packed {
        logic       wr;
        logic       rd;
        logic [3:0] a;
        logic [7:0] d;
        logic [1:0] chk;
        logic [7:0] exp;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        {1'b1,1'b0,4'hC,8'h00,2'd0,8'h00},  // R3 pointer to low
        {1'b1,1'b0,4'h0,8'h34,2'd0,8'h00},  // R2 ch0 addr low
        {1'b1,1'b0,4'h0,8'h12,2'd0,8'h00},  // R2 ch0 addr high
        {1'b0,1'b1,4'h0,8'h00,2'd1,8'h34},  // R2 read low
        {1'b0,1'b1,4'h0,8'h00,2'd1,8'h12},  // R2 read high
        {1'b1,1'b0,4'h3,8'hFF,2'd0,8'h00},  // R4 ch1 count low
        {1'b1,1'b0,4'h3,8'h00,2'd0,8'h00},  // R4 ch1 count high
        {1'b0,1'b1,4'h3,8'h00,2'd1,8'hFF},  // R4 read ch1 count low
        {1'b0,1'b1,4'h2,8'h00,2'd1,8'h00},  // R3 shared pointer: ch1 addr high
        {1'b0,1'b1,4'h3,8'h00,2'd1,8'hFF},  // R3 back to low byte
        {1'b1,1'b0,4'hC,8'h5A,2'd0,8'h00},  // R3 clear pointer, any value
        {1'b0,1'b1,4'h1,8'h00,2'd1,8'h00},  // R3 low byte of ch0 count
        {1'b0,1'b1,4'h8,8'h00,2'd1,8'h00},  // R8 status empty
        {1'b1,1'b0,4'hE,8'h00,2'd0,8'h00},  // R6 clear all masks
        {1'b0,1'b0,4'h0,8'h00,2'd2,8'h00},  // R6 masks zero
        {1'b1,1'b0,4'hA,8'h06,2'd0,8'h00},  // R5 mask ch2
        {1'b0,1'b0,4'h0,8'h00,2'd2,8'h04},  // R5
        {1'b1,1'b0,4'hA,8'h05,2'd0,8'h00},  // R5 mask ch1
        {1'b1,1'b0,4'hA,8'h02,2'd0,8'h00},  // R5 unmask ch2
        {1'b0,1'b0,4'h0,8'h00,2'd2,8'h02},  // R5
        {1'b1,1'b0,4'hF,8'h09,2'd0,8'h00},  // R6 write all masks
        {1'b0,1'b0,4'h0,8'h00,2'd2,8'h09},  // R6
        {1'b1,1'b0,4'h8,8'hA5,2'd1,8'h00},  // R8 command write; R14 rdata idle
        {1'b0,1'b0,4'h0,8'h00,2'd3,8'hA5}   // R8 command held
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one bus cycle; returns read data sampled mid-cycle
    task automatic bus(input logic wr, input logic rd, input logic [3:0] a,
                       input logic [7:0] d, input logic [NCH-1:0] stp,
                       output logic [7:0] q);
        @(negedge clk);
        io_wr = wr; io_rd = rd; io_addr = a; io_wdata = d; xfer_step = stp;
        #4 q = io_rdata;
        @(posedge clk);
        #1 io_wr = 1'b0; io_rd = 1'b0; xfer_step = '0;
    endtask

    function automatic logic [15:0] caddr(input int n); return cur_addr_bus[n*16 +: 16]; endfunction
    function automatic logic [15:0] ccnt(input int n);  return cur_cnt_bus[n*16 +: 16];  endfunction
    function automatic logic [5:0]  cmode(input int n); return chan_mode[n*6 +: 6];       endfunction

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        check("R1 mask", chan_mask, 16'h000F);
        check("R1 cmd", cmd_reg, 16'h0);
        check("R1 mode", 16'(chan_mode == '0), 16'h1);
        check("R1 addr/cnt", 16'((cur_addr_bus | cur_cnt_bus) == '0), 16'h1);
        bus(1'b0, 1'b1, 4'h0, 8'h00, '0, rv); check("R1 ptr low byte", rv, 16'h00);
        bus(1'b0, 1'b1, 4'h8, 8'h00, '0, rv); check("R1 no tc", rv, 16'h00);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            io_wr = VECS[i].wr; io_rd = VECS[i].rd; io_addr = VECS[i].a; io_wdata = VECS[i].d;
            #4;
            case (VECS[i].chk)
                2'd1: check("R2/R3/R4/R8/R14 vector rdata", io_rdata, VECS[i].exp);
                2'd2: check("R5/R6 vector mask", chan_mask, VECS[i].exp);
                2'd3: check("R8 vector cmd", cmd_reg, VECS[i].exp);
                default: ;
            endcase
            @(posedge clk);
            #1 io_wr = 1'b0; io_rd = 1'b0;
        end

        // R7 mode writes
        bus(1'b1, 1'b0, 4'hB, 8'h57, '0, rv);
        bus(1'b1, 1'b0, 4'hB, 8'h45, '0, rv);
        check("R7 ch3 mode", cmode(3), 16'h15);
        check("R7 ch1 mode", cmode(1), 16'h11);
        check("R7 ch0 untouched", cmode(0), 16'h00);

        // R9 master clear
        bus(1'b1, 1'b0, 4'hD, 8'h00, '0, rv);
        check("R9 masks set", chan_mask, 16'h000F);
        check("R9 cmd clear", cmd_reg, 16'h0);
        check("R9 modes clear", 16'(chan_mode == '0), 16'h1);
        bus(1'b0, 1'b1, 4'h0, 8'h00, '0, rv); check("R9 ptr reset, addr kept low", rv, 16'h34);
        bus(1'b0, 1'b1, 4'h0, 8'h00, '0, rv); check("R9 addr kept high", rv, 16'h12);
        bus(1'b0, 1'b1, 4'hD, 8'h00, '0, rv); check("R9 temp reads 0", rv, 16'h00);
        bus(1'b0, 1'b1, 4'hA, 8'h00, '0, rv); check("R14 write-only reads 0", rv, 16'h00);

        // R10 / R11 stepping ch0 with count 1, increment, no auto-init
        bus(1'b1, 1'b0, 4'hC, 8'h00, '0, rv);
        bus(1'b1, 1'b0, 4'h1, 8'h01, '0, rv);
        bus(1'b1, 1'b0, 4'h1, 8'h00, '0, rv);
        bus(1'b1, 1'b0, 4'hB, 8'h44, '0, rv);
        bus(1'b0, 1'b0, 4'h0, 8'h00, 4'b0001, rv);
        check("R10 addr inc", caddr(0), 16'h1235);
        check("R10 cnt dec", ccnt(0), 16'h0000);
        bus(1'b0, 1'b0, 4'h0, 8'h00, 4'b0001, rv);
        check("R11 cnt wraps", ccnt(0), 16'hFFFF);
        check("R10 addr inc again", caddr(0), 16'h1236);
        dreq = 4'hA;
        bus(1'b0, 1'b1, 4'h8, 8'h00, '0, rv); check("R8 status tc+req", rv, 16'hA1);
        bus(1'b0, 1'b1, 4'h8, 8'h00, '0, rv); check("R8 tc cleared by read", rv, 16'hA0);
        bus(1'b1, 1'b0, 4'hC, 8'h00, '0, rv);
        bus(1'b0, 1'b1, 4'h1, 8'h00, '0, rv); check("R11 count low FF", rv, 16'hFF);
        bus(1'b0, 1'b1, 4'h1, 8'h00, '0, rv); check("R11 count high FF", rv, 16'hFF);
        bus(1'b0, 1'b1, 4'h0, 8'h00, '0, rv); check("R2 current addr low", rv, 16'h36);

        // R12 auto-init with decrement on ch2
        bus(1'b1, 1'b0, 4'hC, 8'h00, '0, rv);
        bus(1'b1, 1'b0, 4'h4, 8'h10, '0, rv);
        bus(1'b1, 1'b0, 4'h4, 8'h00, '0, rv);
        bus(1'b1, 1'b0, 4'h5, 8'h01, '0, rv);
        bus(1'b1, 1'b0, 4'h5, 8'h00, '0, rv);
        bus(1'b1, 1'b0, 4'hB, 8'h72, '0, rv);
        bus(1'b0, 1'b0, 4'h0, 8'h00, 4'b0100, rv);
        check("R10 addr dec", caddr(2), 16'h000F);
        check("R10 cnt dec ch2", ccnt(2), 16'h0000);
        bus(1'b0, 1'b0, 4'h0, 8'h00, 4'b0100, rv);
        check("R12 addr reload", caddr(2), 16'h0010);
        check("R12 cnt reload", ccnt(2), 16'h0001);
        bus(1'b0, 1'b1, 4'h8, 8'h00, '0, rv); check("R11 ch2 tc flag", rv, 16'hA4);

        // R13 host write beats a step on the same register
        bus(1'b1, 1'b0, 4'hC, 8'h00, '0, rv);
        bus(1'b1, 1'b0, 4'h3, 8'h22, 4'b0010, rv);
        check("R13 count written not stepped", ccnt(1), 16'h0022);
        check("R13 addr still stepped", caddr(1), 16'h0001);

        bus(1'b0, 1'b0, 4'h0, 8'h00, '0, rv); check("R14 idle rdata", rv, 16'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule